// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

This block holds the pending state of seven interrupt kinds for one processor thread. Each kind owns a 64-bit pending vector and a summary flag. The flag is set whenever any bit of that kind is posted. It drops only when the last bit of the vector has been cleared. Sources raise a bit through a post request and retire it through a clear request. Each request names a kind code and a bit index. A separate clear-all strobe wipes the whole state.

The block also watches two processor mode pins: a hyperprivileged flag and an interrupt-enable flag. From the registered state and those pins it reports three things. The first is whether anything is pending at all. The second is which kind should be taken now. The third is, when the software interrupt kind wins, the level encoded from its vector. A combinational read port returns the full pending vector of any kind.

Requests are single-cycle strobes that are always accepted, so there is no back-pressure on any pin. All pins are plain control and status signals.

Top module: `intr_pend_ctrl`

## Requirements
- R1: After reset every pending vector reads zero, `any_pend` is 0, `sel_valid` is 0, `sel_code` is 0 and `soft_level` is 0.
- R2: A post (`post_en` high) sets bit `post_idx` of the vector of kind `post_code` and that kind's summary flag at the next rising edge.
- R3: A clear (`clr_en` high) resets only bit `clr_idx` of kind `clr_code`. The summary flag of that kind stays set while other bits remain and drops in the same edge that leaves the vector all zero.
- R4: `clr_all` zeroes every vector and every summary flag at the next edge, overriding any post or clear in the same cycle. Reset performs the same clear.
- R5: A post and a clear on the same kind and index in the same cycle leave that bit set.
- R6: A post or clear carrying kind code 7 changes no state.
- R7: `any_pend` is 1 exactly when some summary flag is set, whatever the values of `hpriv` and `ie`.
- R8: Kind codes: 0 trap-level-zero, 1 hypervisor timer match, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 software interrupt, 6 resumable error. With `hpriv` low, codes 0, 1 and 2 may win regardless of `ie`. With `ie` high, codes 3 to 6 may also win. The lowest pending eligible code wins.
- R9: With `hpriv` high and `ie` high, only codes 1 and 2 may win, with code 1 first. With `hpriv` high and `ie` low, nothing is selected.
- R10: When no pending kind is eligible, `sel_valid` is 0 and `sel_code` is 0.
- R11: When code 5 wins, `soft_level` is 14 if bit 0 or bit 16 of its vector is set. Otherwise it is the highest set bit index among bits 15 to 1, or 0 if none of those bits is set. When code 5 does not win, `soft_level` is 0.
- R12: `rd_vec` shows the current vector of kind `rd_code` in the same cycle, and reads zero for code 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| post_en | input | 1 | Post request strobe |
| post_code | input | 3 | Kind code of the post |
| post_idx | input | 6 | Bit index of the post |
| clr_en | input | 1 | Clear request strobe |
| clr_code | input | 3 | Kind code of the clear |
| clr_idx | input | 6 | Bit index of the clear |
| clr_all | input | 1 | Wipe all pending state |
| hpriv | input | 1 | Hyperprivileged mode flag |
| ie | input | 1 | Interrupt enable flag |
| any_pend | output | 1 | Some kind has a pending bit |
| sel_valid | output | 1 | A kind qualifies for selection |
| sel_code | output | 3 | Winning kind code, 0 when none |
| soft_level | output | 4 | Software interrupt level when code 5 wins |
| rd_code | input | 3 | Kind code to read |
| rd_vec | output | 64 | Pending vector of `rd_code` |

## Verification
The hardest state to reach is a full walk down the priority ladder. In that state every kind is pending at once, and each mode combination must pick a different winner or none. The stimulus posts one bit into all seven kinds. It sweeps the four mode combinations, then retires the winners one clear at a time, so each rung is observed in turn. Software interrupt levels are checked with only that kind pending. Vectors are built to hit the alias bits, the scanned range and bits above it. Collisions of post, clear and clear-all are forced in a single cycle.

// File: rtl/intr_pend_pkg.sv
package intr_pend_pkg;
  localparam int NUM_KINDS = 7;
  localparam int CODE_W    = 3;
  localparam int VEC_W     = 64;
  localparam int IDX_W     = $clog2(VEC_W);
  localparam int LVL_W     = 4;

  typedef enum logic [CODE_W-1:0] {
    K_TLZ  = 3'd0,
    K_HTM  = 3'd1,
    K_IVEC = 3'd2,
    K_CMON = 3'd3,
    K_DMON = 3'd4,
    K_SOFT = 3'd5,
    K_RERR = 3'd6
  } intr_kind_e;
endpackage

// File: rtl/intr_pend_bank.sv
module intr_pend_bank #(
  parameter int VEC_W   = 64,
  parameter int IDX_W   = $clog2(VEC_W),
  parameter int CODE_W  = 3,
  parameter int MY_CODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_en,
  input  logic [CODE_W-1:0] post_code,
  input  logic [IDX_W-1:0]  post_idx,
  input  logic              clr_en,
  input  logic [CODE_W-1:0] clr_code,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              clr_all,
  output logic [VEC_W-1:0]  vec_q,
  output logic              stat_q
);
  logic             post_hit, clr_hit;
  logic [VEC_W-1:0] vec_d;
  logic             stat_d;

  assign post_hit = post_en && (post_code == CODE_W'(MY_CODE));
  assign clr_hit  = clr_en  && (clr_code  == CODE_W'(MY_CODE));

  always_comb begin
    vec_d = vec_q;
    if (clr_hit)  vec_d[clr_idx]  = 1'b0;
    if (post_hit) vec_d[post_idx] = 1'b1;
    if (clr_all)  vec_d = '0;
  end

  always_comb begin
    stat_d = stat_q;
    if (clr_all)                     stat_d = 1'b0;
    else if (post_hit)               stat_d = 1'b1;
    else if (clr_hit && vec_d == '0) stat_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      vec_q  <= vec_d;
      stat_q <= stat_d;
    end
  end

  a_r2_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (post_hit && !clr_all) |=> (vec_q[$past(post_idx)] && stat_q));

  a_r3_flag_tracks_vec: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q == (vec_q != '0));

  a_r3_clear_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !post_hit && !clr_all) |=>
      (vec_q == ($past(vec_q) & ~(VEC_W'(1) << $past(clr_idx)))));

  a_r4_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (vec_q == '0 && !stat_q));

  a_r5_post_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (post_hit && clr_hit && post_idx == clr_idx && !clr_all) |=> vec_q[$past(post_idx)]);
endmodule

// File: rtl/intr_soft_level.sv
module intr_soft_level #(
  parameter int VEC_W     = 64,
  parameter int LVL_W     = 4,
  parameter int ALIAS_LO  = 0,
  parameter int ALIAS_HI  = 16,
  parameter int ALIAS_LVL = 14,
  parameter int SCAN_TOP  = 15
) (
  input  logic [VEC_W-1:0] vec,
  output logic [LVL_W-1:0] level
);
  always_comb begin
    level = '0;
    for (int b = 1; b <= SCAN_TOP; b++) begin
      if (vec[b]) level = LVL_W'(b);
    end
    if (vec[ALIAS_LO] || vec[ALIAS_HI]) level = LVL_W'(ALIAS_LVL);
  end
endmodule

// File: rtl/intr_pend_arb.sv
module intr_pend_arb
  import intr_pend_pkg::*;
#(
  parameter int N_KINDS = 7,
  parameter int VEC_W   = 64,
  parameter int LVL_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_KINDS-1:0] stat,
  input  logic               hpriv,
  input  logic               ie,
  input  logic [VEC_W-1:0]   soft_vec,
  output logic               sel_valid,
  output logic [CODE_W-1:0]  sel_code,
  output logic [LVL_W-1:0]   soft_level
);
  logic [N_KINDS-1:0] mask, elig;
  logic [LVL_W-1:0]   enc_level;

  always_comb begin
    mask = '0;
    if (hpriv) begin
      if (ie) begin
        mask[K_HTM]  = 1'b1;
        mask[K_IVEC] = 1'b1;
      end
    end else begin
      mask[K_TLZ]  = 1'b1;
      mask[K_HTM]  = 1'b1;
      mask[K_IVEC] = 1'b1;
      if (ie) mask = '1;
    end
  end

  assign elig = stat & mask;

  always_comb begin
    sel_valid = 1'b0;
    sel_code  = '0;
    for (int k = N_KINDS - 1; k >= 0; k--) begin
      if (elig[k]) begin
        sel_valid = 1'b1;
        sel_code  = CODE_W'(k);
      end
    end
  end

  intr_soft_level #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_soft_level (
    .vec   (soft_vec),
    .level (enc_level)
  );

  assign soft_level = (sel_valid && sel_code == K_SOFT) ? enc_level : '0;

  a_r9_hpriv_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (hpriv && !ie) |-> !sel_valid);

  a_r9_hpriv_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (hpriv && sel_valid) |-> (sel_code == K_HTM || sel_code == K_IVEC));

  a_r8_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> stat[sel_code]);

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (sel_code == '0));

  a_r11_level_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_level != '0) |-> (sel_valid && sel_code == K_SOFT));
endmodule

// File: rtl/intr_pend_ctrl.sv
module intr_pend_ctrl
  import intr_pend_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_en,
  input  logic [CODE_W-1:0] post_code,
  input  logic [IDX_W-1:0]  post_idx,
  input  logic              clr_en,
  input  logic [CODE_W-1:0] clr_code,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              clr_all,
  input  logic              hpriv,
  input  logic              ie,
  output logic              any_pend,
  output logic              sel_valid,
  output logic [CODE_W-1:0] sel_code,
  output logic [LVL_W-1:0]  soft_level,
  input  logic [CODE_W-1:0] rd_code,
  output logic [VEC_W-1:0]  rd_vec
);
  logic [VEC_W-1:0]     vec_arr [NUM_KINDS];
  logic [NUM_KINDS-1:0] stat;

  for (genvar g = 0; g < NUM_KINDS; g++) begin : g_bank
    intr_pend_bank #(
      .VEC_W(VEC_W), .IDX_W(IDX_W), .CODE_W(CODE_W), .MY_CODE(g)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .post_en   (post_en),
      .post_code (post_code),
      .post_idx  (post_idx),
      .clr_en    (clr_en),
      .clr_code  (clr_code),
      .clr_idx   (clr_idx),
      .clr_all   (clr_all),
      .vec_q     (vec_arr[g]),
      .stat_q    (stat[g])
    );
  end

  assign any_pend = |stat;

  always_comb begin
    rd_vec = '0;
    for (int k = 0; k < NUM_KINDS; k++) begin
      if (rd_code == CODE_W'(k)) rd_vec = vec_arr[k];
    end
  end

  intr_pend_arb #(.N_KINDS(NUM_KINDS), .VEC_W(VEC_W), .LVL_W(LVL_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat       (stat),
    .hpriv      (hpriv),
    .ie         (ie),
    .soft_vec   (vec_arr[K_SOFT]),
    .sel_valid  (sel_valid),
    .sel_code   (sel_code),
    .soft_level (soft_level)
  );

  a_r12_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |-> (rd_vec == '0));

  a_r7_pend_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> any_pend);
endmodule

// File: tb/test_intr_pend_ctrl.sv
`timescale 1ns/1ps
module test_intr_pend_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        post_en = 1'b0, clr_en = 1'b0, clr_all = 1'b0;
  logic [2:0]  post_code = '0, clr_code = '0, rd_code = '0;
  logic [5:0]  post_idx = '0, clr_idx = '0;
  logic        hpriv = 1'b0, ie = 1'b0;
  logic        any_pend, sel_valid;
  logic [2:0]  sel_code;
  logic [3:0]  soft_level;
  logic [63:0] rd_vec;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  intr_pend_ctrl i_intr_pend_ctrl (
    .clk(clk), .rst_n(rst_n), .post_en(post_en), .post_code(post_code),
    .post_idx(post_idx), .clr_en(clr_en), .clr_code(clr_code), .clr_idx(clr_idx),
    .clr_all(clr_all), .hpriv(hpriv), .ie(ie), .any_pend(any_pend),
    .sel_valid(sel_valid), .sel_code(sel_code), .soft_level(soft_level),
    .rd_code(rd_code), .rd_vec(rd_vec)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [2:0] c, input logic [63:0] exp);
    rd_code = c;
    #0.5;
    chk(req, rd_vec, exp);
  endtask

  task automatic sel_chk(input string req, input logic h, input logic e,
                         input logic v, input logic [2:0] c, input logic [3:0] l);
    hpriv = h; ie = e;
    #0.5;
    chk({req, " valid"}, 64'(sel_valid), 64'(v));
    chk({req, " code"},  64'(sel_code),  64'(c));
    chk({req, " level"}, 64'(soft_level), 64'(l));
  endtask

  task automatic step(input logic pe, input logic [2:0] pc, input logic [5:0] pi,
                      input logic ce, input logic [2:0] cc, input logic [5:0] ci,
                      input logic ca);
    @(negedge clk);
    post_en = pe; post_code = pc; post_idx = pi;
    clr_en = ce; clr_code = cc; clr_idx = ci; clr_all = ca;
    @(negedge clk);
    post_en = 1'b0; clr_en = 1'b0; clr_all = 1'b0;
  endtask

  task automatic post(input logic [2:0] c, input logic [5:0] i);
    step(1'b1, c, i, 1'b0, 3'd0, 6'd0, 1'b0);
  endtask
  task automatic clear(input logic [2:0] c, input logic [5:0] i);
    step(1'b0, 3'd0, 6'd0, 1'b1, c, i, 1'b0);
  endtask
  task automatic wipe();
    step(1'b0, 3'd0, 6'd0, 1'b0, 3'd0, 6'd0, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 any_pend", 64'(any_pend), 64'd0);
    sel_chk("R1 sel", 1'b0, 1'b1, 1'b0, 3'd0, 4'd0);
    for (int k = 0; k < 7; k++) read_chk("R1 vec", 3'(k), 64'd0);
  endtask

  task automatic t_post_clear();
    post(3'd2, 6'd5);
    read_chk("R2 post bit5", 3'd2, 64'h20);
    chk("R2 any_pend", 64'(any_pend), 64'd1);
    post(3'd2, 6'd40);
    read_chk("R12 read", 3'd2, 64'h0000_0100_0000_0020);
    read_chk("R12 other kind", 3'd3, 64'd0);
    clear(3'd2, 6'd5);
    read_chk("R3 clear one", 3'd2, 64'h0000_0100_0000_0000);
    chk("R3 flag kept", 64'(any_pend), 64'd1);
    clear(3'd2, 6'd40);
    read_chk("R3 empty", 3'd2, 64'd0);
    chk("R3 flag drops", 64'(any_pend), 64'd0);
  endtask

  task automatic t_collide();
    step(1'b1, 3'd4, 6'd9, 1'b1, 3'd4, 6'd9, 1'b0);
    read_chk("R5 post wins", 3'd4, 64'h200);
    post(3'd6, 6'd63);
    step(1'b1, 3'd1, 6'd3, 1'b1, 3'd4, 6'd9, 1'b1);
    chk("R4 wipe any_pend", 64'(any_pend), 64'd0);
    read_chk("R4 wipe k1", 3'd1, 64'd0);
    read_chk("R4 wipe k4", 3'd4, 64'd0);
    read_chk("R4 wipe k6", 3'd6, 64'd0);
  endtask

  task automatic t_bad_code();
    post(3'd7, 6'd1);
    chk("R6 post ignored", 64'(any_pend), 64'd0);
    read_chk("R6 read 7", 3'd7, 64'd0);
    post(3'd0, 6'd2);
    clear(3'd7, 6'd2);
    read_chk("R6 clear ignored", 3'd0, 64'h4);
    wipe();
  endtask

  task automatic t_ladder();
    for (int k = 0; k < 7; k++) post(3'(k), 6'd3);
    sel_chk("R8 all ie1", 1'b0, 1'b1, 1'b1, 3'd0, 4'd0);
    sel_chk("R8 all ie0", 1'b0, 1'b0, 1'b1, 3'd0, 4'd0);
    sel_chk("R9 hpriv ie1", 1'b1, 1'b1, 1'b1, 3'd1, 4'd0);
    sel_chk("R9 hpriv ie0", 1'b1, 1'b0, 1'b0, 3'd0, 4'd0);
    chk("R7 pend hpriv ie0", 64'(any_pend), 64'd1);
    clear(3'd0, 6'd3);
    sel_chk("R8 no tlz", 1'b0, 1'b0, 1'b1, 3'd1, 4'd0);
    clear(3'd1, 6'd3);
    sel_chk("R9 ivec", 1'b1, 1'b1, 1'b1, 3'd2, 4'd0);
    clear(3'd2, 6'd3);
    sel_chk("R10 ie0 none", 1'b0, 1'b0, 1'b0, 3'd0, 4'd0);
    sel_chk("R8 cpu mondo", 1'b0, 1'b1, 1'b1, 3'd3, 4'd0);
    sel_chk("R9 hpriv none", 1'b1, 1'b1, 1'b0, 3'd0, 4'd0);
    chk("R7 pend hpriv", 64'(any_pend), 64'd1);
    clear(3'd3, 6'd3);
    sel_chk("R8 dev mondo", 1'b0, 1'b1, 1'b1, 3'd4, 4'd0);
    clear(3'd4, 6'd3);
    sel_chk("R11 soft lvl3", 1'b0, 1'b1, 1'b1, 3'd5, 4'd3);
    clear(3'd5, 6'd3);
    sel_chk("R8 res err", 1'b0, 1'b1, 1'b1, 3'd6, 4'd0);
    wipe();
  endtask

  task automatic t_soft_levels();
    post(3'd5, 6'd16);
    sel_chk("R11 bit16", 1'b0, 1'b1, 1'b1, 3'd5, 4'd14);
    wipe(); post(3'd5, 6'd0);
    sel_chk("R11 bit0", 1'b0, 1'b1, 1'b1, 3'd5, 4'd14);
    post(3'd5, 6'd15);
    sel_chk("R11 alias beats 15", 1'b0, 1'b1, 1'b1, 3'd5, 4'd14);
    clear(3'd5, 6'd0); post(3'd5, 6'd2);
    sel_chk("R11 highest 15", 1'b0, 1'b1, 1'b1, 3'd5, 4'd15);
    wipe(); post(3'd5, 6'd1);
    sel_chk("R11 bit1", 1'b0, 1'b1, 1'b1, 3'd5, 4'd1);
    wipe(); post(3'd5, 6'd40);
    sel_chk("R11 above range", 1'b0, 1'b1, 1'b1, 3'd5, 4'd0);
    post(3'd5, 6'd7); post(3'd3, 6'd0);
    sel_chk("R11 not winner", 1'b0, 1'b1, 1'b1, 3'd3, 4'd0);
    wipe();
  endtask

  initial begin
    hpriv = 1'b0; ie = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_post_clear();
    t_collide();
    t_bad_code();
    t_ladder();
    t_soft_levels();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule